// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block sits beside a small 8-bit CPU core and decides which of five interrupt requests the core should take. There is one non-maskable request, three vectored maskable requests ranked high, middle and low, and one general maskable request. The vectored requests each have a fixed restart vector. The general request has no vector and instead receives an acknowledge strobe. A global enable flag and three per-source mask bits gate the maskable requests. Software loads the mask bits through a control-word write port and reads them back through a status byte. The same control word also carries a one-bit serial output, and the status byte carries a one-bit serial input.

The core raises `insn_done` for one cycle at each instruction boundary. The controller makes a grant decision only in those cycles. It registers the result, so `take` is a one-cycle pulse in the following cycle, with either a vector address or the general acknowledge. The non-maskable request and the high vectored request are caught on a rising edge and held pending. The middle and low vectored requests and the general request are level-sensitive.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `take`, `vec_valid`, `gen_ack` and `ser_out` are 0, the global enable is 0 and all three mask bits are 1 (masked), so the first status byte read back is 0x07 when `ser_in` is 0.
- R2: A rising edge on `src_trap` is always granted at the next boundary, whatever the global enable and the mask bits are, with vector 0x0024.
- R3: When several requests are eligible, the grant order is trap, then `src_v75`, then `src_v65`, then `src_v55`, then `src_gen`.
- R4: A vectored grant gives `vec_valid`=1 and `vec_addr` 0x0024 (trap), 0x003C (v75), 0x0034 (v65) or 0x002C (v55). A grant to `src_gen` gives `gen_ack`=1, `vec_valid`=0 and `vec_addr`=0.
- R5: Grants occur only at boundaries. `take` is 1 in exactly the cycle after an `insn_done` cycle that grants something. Without `insn_done`, no grant is made.
- R6: `src_v75`, `src_v65` and `src_v55` need the global enable set and their own mask bit clear. `src_gen` needs only the global enable.
- R7: Any grant clears the global enable. `ie_set` sets it and `ie_clr` clears it. In a cycle where a grant coincides with `ie_set`, the grant wins and the enable ends up 0.
- R8: `src_trap` and `src_v75` latch on a rising edge, so a one-cycle pulse is still served later. Each latch clears when its request is granted, and a level held high does not request again. `src_v65` and `src_v55` are level-sensitive: a request that drops before the boundary is not served.
- R9: On a control-word write, each action has its own enable bit:
  - If bit 3 is 1, bits 2:0 load the masks (bit 0 = v55, bit 1 = v65, bit 2 = v75; 1 = masked). If bit 3 is 0, the masks are unchanged.
  - If bit 4 is 1, the v75 latch is cleared.
  - If bit 6 is 1, bit 7 is loaded into `ser_out`. If bit 6 is 0, `ser_out` is unchanged.
- R10: `cfg_rdata` is a registered status byte that follows the state with a one-cycle lag. Its bit positions are: bit 7 = `ser_in`, bit 6 = v75 latch, bit 5 = v65 level, bit 4 = v55 level, bit 3 = global enable, bits 2:0 = masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_trap | input | 1 | Non-maskable request, edge-caught |
| src_v75 | input | 1 | Highest vectored maskable request, edge-caught |
| src_v65 | input | 1 | Middle vectored maskable request, level |
| src_v55 | input | 1 | Lowest vectored maskable request, level |
| src_gen | input | 1 | General maskable request without vector, level |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| ie_set | input | 1 | Set the global enable |
| ie_clr | input | 1 | Clear the global enable |
| cfg_wr | input | 1 | Control-word write strobe |
| cfg_wdata | input | 8 | Control word (accumulator value) |
| ser_in | input | 1 | Serial input bit |
| cfg_rdata | output | 8 | Registered status byte |
| ser_out | output | 1 | Serial output bit |
| take | output | 1 | One-cycle grant pulse to the core |
| vec_valid | output | 1 | The grant carries a vector |
| vec_addr | output | 16 | Restart vector of the granted source |
| gen_ack | output | 1 | Acknowledge strobe for a general-request grant |

## Verification
The priority chain is exercised by raising every maskable request at once and then withdrawing the winner one source at a time, so each grant shows which rank beat which. The trap is mixed with a closed global enable, full masking and a competing high vectored request, which separates "non-maskable" from "merely highest". Pulsed, held and dropped inputs tell edge-caught sources apart from level sources. The latch clear and the mask load are checked through the status byte. Coincident grant and re-enable, a boundary with nothing eligible, and control words with their enable bits cleared cover the corner cases of the enable and write logic.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NSRC   = 5;
  localparam int NMASK  = 3;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;

  // Source indices; a higher index means a higher priority.
  localparam int IDX_GEN  = 0;
  localparam int IDX_V55  = 1;
  localparam int IDX_V65  = 2;
  localparam int IDX_V75  = 3;
  localparam int IDX_TRAP = 4;

  // Sources that are caught on a rising edge.
  localparam logic [NSRC-1:0] EDGE_SRC = (NSRC'(1) << IDX_TRAP) | (NSRC'(1) << IDX_V75);

  // Control-word bit positions.
  localparam int CW_MASK_LO = 0;
  localparam int CW_MASK_LD = 3;
  localparam int CW_CLR75   = 4;
  localparam int CW_SER_LD  = 6;
  localparam int CW_SER_D   = 7;

  // Status-byte bit positions.
  localparam int RD_MASK_LO = 0;
  localparam int RD_IE      = 3;
  localparam int RD_PEND_LO = 4;
  localparam int RD_SER     = 7;

  localparam logic [ADDR_W-1:0] VEC_TRAP = 16'h0024;
  localparam logic [ADDR_W-1:0] VEC_V75  = 16'h003C;
  localparam logic [ADDR_W-1:0] VEC_V65  = 16'h0034;
  localparam logic [ADDR_W-1:0] VEC_V55  = 16'h002C;

  // Returns a one-hot vector with only the highest set bit of req kept.
  function automatic logic [NSRC-1:0] pick_top(input logic [NSRC-1:0] req);
    logic [NSRC-1:0] res;
    logic            hit;
    res = '0;
    hit = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i] && !hit) begin
        res[i] = 1'b1;
        hit    = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic logic [ADDR_W-1:0] vec_of(input int idx);
    case (idx)
      IDX_TRAP: vec_of = VEC_TRAP;
      IDX_V75:  vec_of = VEC_V75;
      IDX_V65:  vec_of = VEC_V65;
      IDX_V55:  vec_of = VEC_V55;
      default:  vec_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture
  import prio_irq_pkg::*;
#(
  parameter int              N_SRC    = NSRC,
  parameter logic [N_SRC-1:0] EDGE_SEL = EDGE_SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] raw,
  input  logic [N_SRC-1:0] clr,
  output logic [N_SRC-1:0] pend
);
  logic [N_SRC-1:0] smp_q;
  logic [N_SRC-1:0] prv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= '0;
      prv_q <= '0;
    end else begin
      smp_q <= raw;
      prv_q <= smp_q;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (EDGE_SEL[i]) begin : g_edge
      logic lat_q;
      always_ff @(posedge clk) begin
        if (rst) lat_q <= 1'b0;
        else     lat_q <= (lat_q & ~clr[i]) | (smp_q[i] & ~prv_q[i]);
      end
      assign pend[i] = lat_q;
    end else begin : g_level
      assign pend[i] = smp_q[i];
    end
  end

  logic unused_clr;
  assign unused_clr = ^(clr & ~EDGE_SEL);
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import prio_irq_pkg::*;
#(
  parameter int N_SRC  = NSRC,
  parameter int N_MASK = NMASK,
  parameter int DW     = DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              accept,
  input  logic              ser_in,
  input  logic [N_SRC-1:0]  pend,
  output logic [N_MASK-1:0] mask_q,
  output logic              ie_q,
  output logic              ser_out,
  output logic [DW-1:0]     rdata,
  output logic              clr_v75
);
  assign clr_v75 = cfg_wr & cfg_wdata[CW_CLR75];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      ie_q    <= 1'b0;
      ser_out <= 1'b0;
    end else begin
      if (cfg_wr && cfg_wdata[CW_MASK_LD])
        mask_q <= cfg_wdata[CW_MASK_LO +: N_MASK];
      if (cfg_wr && cfg_wdata[CW_SER_LD])
        ser_out <= cfg_wdata[CW_SER_D];
      if (accept)      ie_q <= 1'b0;
      else if (ie_clr) ie_q <= 1'b0;
      else if (ie_set) ie_q <= 1'b1;
    end
  end

  logic [DW-1:0] stat;
  always_comb begin
    stat                           = '0;
    stat[RD_MASK_LO +: N_MASK]     = mask_q;
    stat[RD_IE]                    = ie_q;
    stat[RD_PEND_LO +: N_MASK]     = pend[IDX_V55 +: N_MASK];
    stat[RD_SER]                   = ser_in;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= stat;
  end

  logic unused_bits;
  assign unused_bits = cfg_wdata[5] ^ pend[IDX_GEN] ^ pend[IDX_TRAP];
endmodule

// File: rtl/irq_select.sv
module irq_select
  import prio_irq_pkg::*;
#(
  parameter int N_SRC  = NSRC,
  parameter int N_MASK = NMASK,
  parameter int AW     = ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_done,
  input  logic [N_SRC-1:0]  pend,
  input  logic [N_MASK-1:0] mask_q,
  input  logic              ie_q,
  output logic              accept,
  output logic [N_SRC-1:0]  grant,
  output logic              take,
  output logic              vec_valid,
  output logic [AW-1:0]     vec_addr,
  output logic              gen_ack
);
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] win;
  logic [AW-1:0]    addr_d;

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    if (i == IDX_TRAP) begin : g_nmi
      assign elig[i] = pend[i];
    end else if (i == IDX_GEN) begin : g_gen
      assign elig[i] = pend[i] & ie_q;
    end else begin : g_vec
      assign elig[i] = pend[i] & ie_q & ~mask_q[i - IDX_V55];
    end
  end

  assign win    = pick_top(elig);
  assign grant  = insn_done ? win : '0;
  assign accept = |grant;

  always_comb begin
    addr_d = '0;
    for (int i = 0; i < N_SRC; i++)
      if (grant[i]) addr_d = addr_d | vec_of(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take      <= 1'b0;
      vec_valid <= 1'b0;
      vec_addr  <= '0;
      gen_ack   <= 1'b0;
    end else begin
      take      <= accept;
      vec_valid <= accept & ~grant[IDX_GEN];
      vec_addr  <= addr_d;
      gen_ack   <= grant[IDX_GEN];
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              src_trap,
  input  logic              src_v75,
  input  logic              src_v65,
  input  logic              src_v55,
  input  logic              src_gen,
  input  logic              insn_done,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              ser_in,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              ser_out,
  output logic              take,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              gen_ack
);
  logic [NSRC-1:0]  raw;
  logic [NSRC-1:0]  pend;
  logic [NSRC-1:0]  grant;
  logic [NSRC-1:0]  clr;
  logic [NMASK-1:0] mask_q;
  logic             ie_q;
  logic             accept;
  logic             clr_v75;

  always_comb begin
    raw           = '0;
    raw[IDX_TRAP] = src_trap;
    raw[IDX_V75]  = src_v75;
    raw[IDX_V65]  = src_v65;
    raw[IDX_V55]  = src_v55;
    raw[IDX_GEN]  = src_gen;
  end

  assign clr = grant | (NSRC'(clr_v75) << IDX_V75);

  irq_req_capture #(.N_SRC(NSRC), .EDGE_SEL(EDGE_SRC)) u_cap (
    .clk(clk), .rst(rst), .raw(raw), .clr(clr), .pend(pend)
  );

  irq_mask_regs #(.N_SRC(NSRC), .N_MASK(NMASK), .DW(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .ie_set(ie_set), .ie_clr(ie_clr), .accept(accept), .ser_in(ser_in),
    .pend(pend), .mask_q(mask_q), .ie_q(ie_q), .ser_out(ser_out),
    .rdata(cfg_rdata), .clr_v75(clr_v75)
  );

  irq_select #(.N_SRC(NSRC), .N_MASK(NMASK), .AW(ADDR_W)) u_sel (
    .clk(clk), .rst(rst), .insn_done(insn_done), .pend(pend),
    .mask_q(mask_q), .ie_q(ie_q), .accept(accept), .grant(grant),
    .take(take), .vec_valid(vec_valid), .vec_addr(vec_addr), .gen_ack(gen_ack)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              insn_done,
  input logic              cfg_wr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              take,
  input logic              vec_valid,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              gen_ack,
  input logic              ser_out,
  input logic              ie_q,
  input logic [NSRC-1:0]   pend
);
  a_r2_trap_wins: assert property (@(posedge clk) disable iff (rst)
    insn_done && pend[IDX_TRAP] |=> take && vec_valid && vec_addr == VEC_TRAP);

  a_r4_one_kind: assert property (@(posedge clk) disable iff (rst)
    take |-> (vec_valid ^ gen_ack));

  a_r4_gen_no_vec: assert property (@(posedge clk) disable iff (rst)
    gen_ack |-> vec_addr == '0 && !vec_valid);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !take |-> !vec_valid && !gen_ack);

  a_r5_at_boundary: assert property (@(posedge clk) disable iff (rst)
    insn_done == 1'b0 |=> !take);

  a_r6_gate_closed: assert property (@(posedge clk) disable iff (rst)
    insn_done && !ie_q && !pend[IDX_TRAP] |=> !take);

  a_r7_ie_dropped: assert property (@(posedge clk) disable iff (rst)
    take |-> !ie_q);

  a_r9_ser_load: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && cfg_wdata[CW_SER_LD] |=> ser_out == $past(cfg_wdata[CW_SER_D]));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .insn_done(insn_done), .cfg_wr(cfg_wr),
  .cfg_wdata(cfg_wdata), .take(take), .vec_valid(vec_valid),
  .vec_addr(vec_addr), .gen_ack(gen_ack), .ser_out(ser_out),
  .ie_q(ie_q), .pend(pend)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        src_trap = 0, src_v75 = 0, src_v65 = 0, src_v55 = 0, src_gen = 0;
  logic        insn_done = 0, ie_set = 0, ie_clr = 0, cfg_wr = 0, ser_in = 0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        ser_out, take, vec_valid, gen_ack;
  logic [15:0] vec_addr;
  int          nchk = 0;
  int          nfail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst(rst), .src_trap(src_trap), .src_v75(src_v75),
    .src_v65(src_v65), .src_v55(src_v55), .src_gen(src_gen),
    .insn_done(insn_done), .ie_set(ie_set), .ie_clr(ie_clr),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .ser_in(ser_in),
    .cfg_rdata(cfg_rdata), .ser_out(ser_out), .take(take),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .gen_ack(gen_ack)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    repeat (3) tick();
  endtask

  task automatic boundary();
    insn_done = 1; tick(); insn_done = 0;
  endtask

  task automatic en();
    ie_set = 1; tick(); ie_set = 0;
  endtask

  task automatic dis();
    ie_clr = 1; tick(); ie_clr = 0;
  endtask

  task automatic wr_cfg(input logic [7:0] d);
    cfg_wr = 1; cfg_wdata = d; tick(); cfg_wr = 0; cfg_wdata = '0;
  endtask

  // Checks one granted cycle: take, vec_valid, gen_ack and the address.
  task automatic expect_grant(input string tag, input logic tk, input logic vv,
                              input logic ga, input logic [15:0] ad);
    chk({tag, " take"}, 16'(take), 16'(tk));
    chk({tag, " vec_valid"}, 16'(vec_valid), 16'(vv));
    chk({tag, " gen_ack"}, 16'(gen_ack), 16'(ga));
    chk({tag, " vec_addr"}, vec_addr, ad);
  endtask

  task automatic t_reset();
    rst = 1; repeat (3) tick(); rst = 0; tick();
    expect_grant("R1 reset", 0, 0, 0, 16'h0);
    chk("R1 ser_out", 16'(ser_out), 16'h0);
    chk("R1 status", 16'(cfg_rdata), 16'h07);
  endtask

  task automatic t_boundary();
    en(); src_gen = 1; settle();
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R5 no boundary", 16'(take), 16'h0);
    end
    boundary();
    expect_grant("R4 R5 gen grant", 1, 0, 1, 16'h0000);
    tick();
    chk("R5 single pulse", 16'(take), 16'h0);
  endtask

  task automatic t_enable();
    boundary();
    chk("R6 gen needs enable", 16'(take), 16'h0);
    en(); boundary();
    chk("R7 re-enabled", 16'(gen_ack), 16'h1);
    boundary();
    chk("R7 grant clears enable", 16'(take), 16'h0);
    en(); dis(); boundary();
    chk("R7 ie_clr", 16'(take), 16'h0);
    en();
    ie_set = 1; insn_done = 1; tick(); ie_set = 0; insn_done = 0;
    chk("R7 grant with ie_set", 16'(gen_ack), 16'h1);
    boundary();
    chk("R7 grant beats ie_set", 16'(take), 16'h0);
    src_gen = 0; tick();
  endtask

  task automatic t_mask();
    src_v55 = 1; en(); settle(); boundary();
    chk("R6 v55 masked", 16'(take), 16'h0);
    wr_cfg(8'h0E); boundary();
    expect_grant("R9 R4 v55 unmasked", 1, 1, 0, 16'h002C);
    src_v55 = 0;
    wr_cfg(8'h07); tick();
    chk("R9 masks kept without load bit", 16'(cfg_rdata[2:0]), 16'h6);
  endtask

  task automatic t_prio();
    wr_cfg(8'h08);
    src_gen = 1; src_v55 = 1; src_v65 = 1; src_v75 = 1; tick(); src_v75 = 0;
    settle();
    en(); boundary();
    expect_grant("R3 v75 first", 1, 1, 0, 16'h003C);
    en(); boundary();
    expect_grant("R3 v65 next", 1, 1, 0, 16'h0034);
    src_v65 = 0; settle(); en(); boundary();
    expect_grant("R3 v55 next", 1, 1, 0, 16'h002C);
    src_v55 = 0; settle(); en(); boundary();
    expect_grant("R3 gen last", 1, 0, 1, 16'h0000);
    src_gen = 0; tick();
  endtask

  task automatic t_trap();
    src_v65 = 1; src_trap = 1; tick(); src_trap = 0; settle();
    boundary();
    expect_grant("R2 trap with enable off", 1, 1, 0, 16'h0024);
    boundary();
    chk("R8 trap latch cleared", 16'(take), 16'h0);
    src_v65 = 0;
    en(); src_v75 = 1; src_trap = 1; tick(); src_v75 = 0; src_trap = 0; settle();
    boundary();
    expect_grant("R2 R3 trap over v75", 1, 1, 0, 16'h0024);
    en(); boundary();
    expect_grant("R8 v75 kept pending", 1, 1, 0, 16'h003C);
    wr_cfg(8'h0F);
    src_trap = 1; tick(); src_trap = 0; settle(); boundary();
    expect_grant("R2 trap with all masked", 1, 1, 0, 16'h0024);
    wr_cfg(8'h08);
  endtask

  task automatic t_edge();
    src_v75 = 1; settle(); en(); boundary();
    expect_grant("R8 v75 held", 1, 1, 0, 16'h003C);
    en(); boundary();
    chk("R8 held v75 no retrigger", 16'(take), 16'h0);
    src_v75 = 0; tick();
    src_v75 = 1; tick(); src_v75 = 0; settle();
    chk("R10 v75 latch visible", 16'(cfg_rdata[6]), 16'h1);
    wr_cfg(8'h18); tick();
    chk("R9 latch cleared by write", 16'(cfg_rdata[6]), 16'h0);
    boundary();
    chk("R9 cleared v75 not served", 16'(take), 16'h0);
    src_v65 = 1; tick(); src_v65 = 0; settle(); boundary();
    chk("R8 dropped level not served", 16'(take), 16'h0);
  endtask

  task automatic t_read();
    dis(); ser_in = 1; src_v55 = 1; wr_cfg(8'h0A); en(); settle();
    chk("R10 status layout", 16'(cfg_rdata), 16'h9A);
    ser_in = 0; src_v55 = 0; dis(); settle();
    chk("R10 status idle", 16'(cfg_rdata), 16'h02);
  endtask

  task automatic t_ser();
    wr_cfg(8'hC0);
    chk("R9 ser_out set", 16'(ser_out), 16'h1);
    wr_cfg(8'h80);
    chk("R9 ser_out kept without load bit", 16'(ser_out), 16'h1);
    wr_cfg(8'h40);
    chk("R9 ser_out cleared", 16'(ser_out), 16'h0);
  endtask

  initial begin
    t_reset();
    t_boundary();
    t_enable();
    t_mask();
    t_prio();
    t_trap();
    t_edge();
    t_read();
    t_ser();
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule